// File: doc/BRIEF.md
# Cross-Lane Data Sharing Unit

This unit moves 32-bit values between the lanes of a 64-lane wavefront in a single registered step. The lanes form four rows of sixteen. Each row is split into four banks of four lanes. A caller presents three things together with a valid strobe: a source vector, the old destination vector and an operation code. One cycle later the unit returns the new destination vector. In that vector each lane holds one of three things: a value read from another lane, zero, or its old value.

The operations cover the following:
- a four-lane permute that is the same in every aligned quad;
- a full-row mirror and a half-row mirror;
- row-scope shift left, shift right and rotate right by a programmable amount;
- wave-scope shifts and rotates by one lane;
- two row broadcasts.

A row mask and a bank mask select which lanes may be written. A bound-zero flag decides what a lane receives when its source lies outside the legal range.

In this document, "lane i gets lane s" means the destination lane i takes the source value of lane s.

Top module: `lane_share_top`

## Requirements
- R1: While reset is low, and after it is released until the first valid input, outValid is 0 and every lane of dstVec is 0.
- R2: A result appears on dstVec with outValid high in the cycle after inValid is sampled high. In a cycle after inValid is sampled low, outValid is 0 and dstVec holds its value.
- R3: opCode 0 (quad permute): lane i gets lane 4*(i/4)+quadSel[2k+1:2k], where k = i%4.
- R4: opCode 1 (row mirror): lane p of a row gets lane 15-p of the same row. opCode 2 (half mirror): within each 8-lane half row, lane p gets lane 7-p.
- R5: Row ops use amount n = shiftAmt, where 0 means no movement. In each row, for position p:
  - opCode 3 (row shift left): lane p gets lane p+n, and the source is invalid when p+n > 15.
  - opCode 4 (row shift right): lane p gets lane p-n, and the source is invalid when p < n.
  - opCode 5 (row rotate right): lane p gets lane (p-n) mod 16.
- R6: The wave ops move data by one lane across all 64 lanes:
  - opCode 6 (shift left): lane i gets lane i+1, and lane 63 has an invalid source.
  - opCode 7 (rotate left): lane i gets lane (i+1) mod 64.
  - opCode 8 (shift right): lane i gets lane i-1, and lane 0 has an invalid source.
  - opCode 9 (rotate right): lane i gets lane (i-1) mod 64.
- R7: opCode 10: every lane of row r gets lane 16r-1, and row 0 has an invalid source. opCode 11: every lane of rows 2 and 3 gets lane 31, and rows 0 and 1 have an invalid source.
- R8: Lane i is enabled only when rowMask[i/16] and bankMask[(i%16)/4] are both 1. A disabled lane takes its oldVec value.
- R9: An enabled lane with an invalid source takes 0 when boundZero is 1. When boundZero is 0 it takes its oldVec value.
- R10: opCodes 12 to 15 write no lane, so every lane takes its oldVec value whatever the masks or boundZero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Inputs are valid this cycle |
| opCode | input | 4 | Sharing operation code |
| shiftAmt | input | 4 | Amount for row shifts and rotates |
| quadSel | input | 8 | Four 2-bit quad permute selectors |
| rowMask | input | 4 | Per-row write enable |
| bankMask | input | 4 | Per-bank write enable |
| boundZero | input | 1 | Invalid source reads as zero |
| srcVec | input | 2048 | Source value per lane, lane i at [32i+31:32i] |
| oldVec | input | 2048 | Old destination value per lane |
| outValid | output | 1 | dstVec holds a new result |
| dstVec | output | 2048 | New destination value per lane |

## Verification
The unit holds one real piece of state, the destination register. Any other fault is in the per-lane source index, the validity flag or the enable. Such a fault shows on dstVec in the cycle right after the operation is issued. It appears as the wrong lane's value, as an unexpected zero, or as an old value where a source value should be. A wrong validity flag shows only at range edges: the lanes shifted out, lane 0 or lane 63 of the wave shifts, and the rows a broadcast does not cover. The directed cases aim at exactly these lanes, using both settings of boundZero.

// File: rtl/lane_share_pkg.sv
`timescale 1ns/1ps
package lane_share_pkg;
  localparam int NUM_ROWS   = 4;
  localparam int BANK_LANES = 4;
  localparam int ROW_LANES  = 16;
  localparam int LANES      = NUM_ROWS * ROW_LANES;
  localparam int BANKS      = ROW_LANES / BANK_LANES;
  localparam int IDX_W      = $clog2(LANES);
  localparam int AMT_W      = $clog2(ROW_LANES);
  localparam int QSEL_W     = 2 * BANK_LANES;

  typedef enum logic [3:0] {
    OP_QUAD     = 4'd0,
    OP_ROW_MIR  = 4'd1,
    OP_HALF_MIR = 4'd2,
    OP_ROW_SHL  = 4'd3,
    OP_ROW_SHR  = 4'd4,
    OP_ROW_ROR  = 4'd5,
    OP_WAVE_SHL = 4'd6,
    OP_WAVE_ROL = 4'd7,
    OP_WAVE_SHR = 4'd8,
    OP_WAVE_ROR = 4'd9,
    OP_BC15     = 4'd10,
    OP_BC31     = 4'd11
  } shareOp_e;

  typedef struct packed {
    logic              fire;
    logic              quad;
    logic              rowMirror;
    logic              halfMirror;
    logic              rowShl;
    logic              rowShr;
    logic              rowRor;
    logic              waveShl;
    logic              waveRol;
    logic              waveShr;
    logic              waveRor;
    logic              bc15;
    logic              bc31;
    logic              boundZero;
    logic [AMT_W-1:0]  amount;
    logic [QSEL_W-1:0] quadSel;
    logic [NUM_ROWS-1:0] rowEn;
    logic [BANKS-1:0]  bankEn;
  } shareStrobe_t;
endpackage

// File: rtl/lane_share_ctrl.sv
`timescale 1ns/1ps
module lane_share_ctrl
  import lane_share_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [3:0]          opCode,
  input  logic [AMT_W-1:0]    shiftAmt,
  input  logic [QSEL_W-1:0]   quadSel,
  input  logic [NUM_ROWS-1:0] rowMask,
  input  logic [BANKS-1:0]    bankMask,
  input  logic                boundZero,
  output shareStrobe_t        strb,
  output logic                outValid
);
  logic knownOp;

  always_comb begin
    strb           = '0;
    knownOp        = 1'b1;
    strb.fire      = inValid;
    strb.boundZero = boundZero;
    strb.amount    = shiftAmt;
    strb.quadSel   = quadSel;
    case (opCode)
      OP_QUAD:     strb.quad       = 1'b1;
      OP_ROW_MIR:  strb.rowMirror  = 1'b1;
      OP_HALF_MIR: strb.halfMirror = 1'b1;
      OP_ROW_SHL:  strb.rowShl     = 1'b1;
      OP_ROW_SHR:  strb.rowShr     = 1'b1;
      OP_ROW_ROR:  strb.rowRor     = 1'b1;
      OP_WAVE_SHL: strb.waveShl    = 1'b1;
      OP_WAVE_ROL: strb.waveRol    = 1'b1;
      OP_WAVE_SHR: strb.waveShr    = 1'b1;
      OP_WAVE_ROR: strb.waveRor    = 1'b1;
      OP_BC15:     strb.bc15       = 1'b1;
      OP_BC31:     strb.bc31       = 1'b1;
      default:     knownOp         = 1'b0;
    endcase
    // unknown codes disable every lane so old values pass through
    strb.rowEn  = knownOp ? rowMask  : '0;
    strb.bankEn = knownOp ? bankMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: valid strobe follows the input by exactly one cycle
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R10 and others: at most one operation strobe at a time
  a_r10_single_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.quad, strb.rowMirror, strb.halfMirror, strb.rowShl,
              strb.rowShr, strb.rowRor, strb.waveShl, strb.waveRol,
              strb.waveShr, strb.waveRor, strb.bc15, strb.bc31}));
endmodule

// File: rtl/lane_share_dp.sv
`timescale 1ns/1ps
module lane_share_dp
  import lane_share_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  shareStrobe_t             strb,
  input  logic [LANES*DATA_W-1:0]  srcVec,
  input  logic [LANES*DATA_W-1:0]  oldVec,
  output logic [LANES*DATA_W-1:0]  dstVec
);
  logic [DATA_W-1:0] srcLane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign srcLane[g] = srcVec[g*DATA_W +: DATA_W];
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam logic [IDX_W-1:0] LIDX  = IDX_W'(L);
    localparam logic [1:0]       ROW2  = 2'(L / ROW_LANES);
    localparam logic [AMT_W-1:0] POS   = AMT_W'(L % ROW_LANES);
    localparam int               BANK  = (L % ROW_LANES) / BANK_LANES;
    localparam int               QP    = 2 * (L % BANK_LANES);
    localparam bit               IS_LAST  = (L == LANES - 1);
    localparam bit               IS_FIRST = (L == 0);

    logic [IDX_W-1:0]  idx;
    logic              srcOk;
    logic [AMT_W:0]    sumUp;
    logic [AMT_W-1:0]  posDown;
    logic              laneEn;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      sumUp   = {1'b0, POS} + {1'b0, strb.amount};
      posDown = POS - strb.amount;
      idx     = LIDX;
      srcOk   = 1'b0;
      if (strb.quad) begin
        idx   = {LIDX[IDX_W-1:2], strb.quadSel[QP +: 2]};
        srcOk = 1'b1;
      end else if (strb.rowMirror) begin
        idx   = {ROW2, ~POS};
        srcOk = 1'b1;
      end else if (strb.halfMirror) begin
        idx   = {ROW2, POS[3], ~POS[2:0]};
        srcOk = 1'b1;
      end else if (strb.rowShl) begin
        idx   = {ROW2, sumUp[AMT_W-1:0]};
        srcOk = !sumUp[AMT_W];
      end else if (strb.rowShr) begin
        idx   = {ROW2, posDown};
        srcOk = (POS >= strb.amount);
      end else if (strb.rowRor) begin
        idx   = {ROW2, posDown};
        srcOk = 1'b1;
      end else if (strb.waveShl) begin
        idx   = LIDX + 1'b1;
        srcOk = !IS_LAST;
      end else if (strb.waveRol) begin
        idx   = LIDX + 1'b1;
        srcOk = 1'b1;
      end else if (strb.waveShr) begin
        idx   = LIDX - 1'b1;
        srcOk = !IS_FIRST;
      end else if (strb.waveRor) begin
        idx   = LIDX - 1'b1;
        srcOk = 1'b1;
      end else if (strb.bc15) begin
        idx   = {ROW2 - 2'd1, 4'hF};
        srcOk = (ROW2 != 2'd0);
      end else if (strb.bc31) begin
        idx   = IDX_W'(31);
        srcOk = ROW2[1];
      end
    end

    assign laneEn = strb.rowEn[ROW2] & strb.bankEn[BANK];

    always_comb begin
      if (!laneEn)        nxt = oldVec[L*DATA_W +: DATA_W];
      else if (srcOk)     nxt = srcLane[idx];
      else if (strb.boundZero) nxt = '0;
      else                nxt = oldVec[L*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN)          dstVec[L*DATA_W +: DATA_W] <= '0;
      else if (strb.fire) dstVec[L*DATA_W +: DATA_W] <= nxt;
    end
  end

  localparam int TOP = (LANES - 1) * DATA_W;

  // R2: no strobe, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fire |=> $stable(dstVec));
  // R8: lane 0 disabled keeps old value
  a_r8_masked_hold: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire && !(strb.rowEn[0] && strb.bankEn[0])
    |=> dstVec[DATA_W-1:0] == $past(oldVec[DATA_W-1:0]));
  // R9: top lane shifted out of the wave reads zero
  a_r9_edge_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire && strb.waveShl && strb.boundZero
      && strb.rowEn[NUM_ROWS-1] && strb.bankEn[BANKS-1]
    |=> dstVec[TOP +: DATA_W] == '0);
  // R6: wave rotate left wraps lane 0 into the top lane
  a_r6_rol_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire && strb.waveRol && strb.rowEn[NUM_ROWS-1] && strb.bankEn[BANKS-1]
    |=> dstVec[TOP +: DATA_W] == $past(srcVec[DATA_W-1:0]));
endmodule

// File: rtl/lane_share_top.sv
`timescale 1ns/1ps
module lane_share_top
  import lane_share_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [3:0]              opCode,
  input  logic [AMT_W-1:0]        shiftAmt,
  input  logic [QSEL_W-1:0]       quadSel,
  input  logic [NUM_ROWS-1:0]     rowMask,
  input  logic [BANKS-1:0]        bankMask,
  input  logic                    boundZero,
  input  logic [LANES*DATA_W-1:0] srcVec,
  input  logic [LANES*DATA_W-1:0] oldVec,
  output logic                    outValid,
  output logic [LANES*DATA_W-1:0] dstVec
);
  shareStrobe_t strb;

  lane_share_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .shiftAmt(shiftAmt), .quadSel(quadSel), .rowMask(rowMask),
    .bankMask(bankMask), .boundZero(boundZero), .strb(strb),
    .outValid(outValid)
  );

  lane_share_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .srcVec(srcVec),
    .oldVec(oldVec), .dstVec(dstVec)
  );
endmodule

// File: tb/lane_share_top_tb_top.sv
`timescale 1ns/1ps
module lane_share_top_tb_top;
  localparam int W  = 32;
  localparam int N  = 64;
  localparam int VW = W * N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] opCode = '0, shiftAmt = '0, rowMask = '1, bankMask = '1;
  logic [7:0] quadSel = '0;
  logic boundZero = 1'b0;
  logic [VW-1:0] srcVec = '0, oldVec = '0;
  logic outValid;
  logic [VW-1:0] dstVec;
  logic [VW-1:0] lastExp;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_share_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .shiftAmt(shiftAmt), .quadSel(quadSel), .rowMask(rowMask),
    .bankMask(bankMask), .boundZero(boundZero), .srcVec(srcVec),
    .oldVec(oldVec), .outValid(outValid), .dstVec(dstVec)
  );

  function automatic logic [VW-1:0] model(input int op, input int amt,
      input logic [7:0] qs, input logic [3:0] rm, input logic [3:0] bm,
      input logic bz, input logic [VW-1:0] src, input logic [VW-1:0] old);
    logic [VW-1:0] r;
    for (int i = 0; i < N; i++) begin
      int row, pos, bank, s;
      bit ok, en;
      logic [W-1:0] v;
      row = i / 16; pos = i % 16; bank = pos / 4; s = i; ok = 0;
      case (op)
        0: begin s = (i / 4) * 4 + int'(qs[2*(i%4) +: 2]); ok = 1; end
        1: begin s = row * 16 + 15 - pos; ok = 1; end
        2: begin s = row * 16 + (pos / 8) * 8 + 7 - (pos % 8); ok = 1; end
        3: begin ok = (pos + amt) < 16; s = row * 16 + pos + amt; end
        4: begin ok = pos >= amt; s = row * 16 + pos - amt; end
        5: begin s = row * 16 + ((pos - amt + 16) % 16); ok = 1; end
        6: begin ok = i < 63; s = i + 1; end
        7: begin s = (i + 1) % 64; ok = 1; end
        8: begin ok = i > 0; s = i - 1; end
        9: begin s = (i + 63) % 64; ok = 1; end
        10: begin ok = row > 0; s = row * 16 - 1; end
        11: begin ok = row >= 2; s = 31; end
        default: ok = 0;
      endcase
      en = rm[row] && bm[bank] && (op <= 11);
      v = old[i*W +: W];
      if (en) begin
        if (ok)      v = src[s*W +: W];
        else if (bz) v = '0;
      end
      r[i*W +: W] = v;
    end
    return r;
  endfunction

  function automatic string tagFor(input int op);
    case (op)
      0: return "R3";
      1, 2: return "R4";
      3, 4, 5: return "R5";
      6, 7, 8, 9: return "R6";
      10, 11: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic checkVec(input string tag, input logic [VW-1:0] exp);
    checks++;
    if (dstVec !== exp) begin
      errors++;
      for (int i = 0; i < N; i++) begin
        if (dstVec[i*W +: W] !== exp[i*W +: W]) begin
          $display("FAIL %s lane %0d: got %h expected %h", tag, i,
                   dstVec[i*W +: W], exp[i*W +: W]);
          break;
        end
      end
    end
  endtask

  task automatic checkBit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s outValid: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic scramble();
    for (int i = 0; i < N; i++) begin
      srcVec[i*W +: W] = $urandom;
      oldVec[i*W +: W] = $urandom;
    end
  endtask

  task automatic runOp(input int op, input int amt, input logic [7:0] qs,
      input logic [3:0] rm, input logic [3:0] bm, input logic bz,
      input string tag);
    @(negedge clk);
    scramble();
    opCode = 4'(op); shiftAmt = 4'(amt); quadSel = qs;
    rowMask = rm; bankMask = bm; boundZero = bz; inValid = 1'b1;
    lastExp = model(op, amt, qs, rm, bm, bz, srcVec, oldVec);
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R2", outValid, 1'b1);
    checkVec(tag, lastExp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    checkBit("R1", outValid, 1'b0);
    checkVec("R1", '0);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R1", outValid, 1'b0);
    checkVec("R1", '0);

    // directed: every operation with full masks
    runOp(0, 0, 8'b00_01_10_11, 4'hF, 4'hF, 0, "R3");
    runOp(0, 0, 8'b10_10_10_10, 4'hF, 4'hF, 0, "R3");
    runOp(1, 0, 8'h00, 4'hF, 4'hF, 0, "R4");
    runOp(2, 0, 8'h00, 4'hF, 4'hF, 0, "R4");
    runOp(3, 15, 8'h00, 4'hF, 4'hF, 1, "R5");
    runOp(3, 0, 8'h00, 4'hF, 4'hF, 1, "R5");
    runOp(4, 15, 8'h00, 4'hF, 4'hF, 0, "R5");
    runOp(4, 3, 8'h00, 4'hF, 4'hF, 1, "R5");
    runOp(5, 1, 8'h00, 4'hF, 4'hF, 0, "R5");
    runOp(5, 15, 8'h00, 4'hF, 4'hF, 0, "R5");
    runOp(6, 0, 8'h00, 4'hF, 4'hF, 1, "R6");
    runOp(7, 0, 8'h00, 4'hF, 4'hF, 0, "R6");
    runOp(8, 0, 8'h00, 4'hF, 4'hF, 0, "R6");
    runOp(9, 0, 8'h00, 4'hF, 4'hF, 1, "R6");
    runOp(10, 0, 8'h00, 4'hF, 4'hF, 1, "R7");
    runOp(11, 0, 8'h00, 4'hF, 4'hF, 0, "R7");
    runOp(11, 0, 8'h00, 4'hF, 4'hF, 1, "R9");
    runOp(8, 0, 8'h00, 4'hF, 4'hF, 1, "R9");
    // write masks
    runOp(7, 0, 8'h00, 4'b1010, 4'b0110, 0, "R8");
    runOp(1, 0, 8'h00, 4'b0001, 4'b1000, 1, "R8");
    runOp(3, 12, 8'h00, 4'b1100, 4'b0011, 1, "R8");
    // unused code
    runOp(13, 4, 8'hFF, 4'hF, 4'hF, 1, "R10");
    runOp(15, 0, 8'h00, 4'hF, 4'hF, 0, "R10");
    // hold with valid low
    @(negedge clk);
    scramble();
    checkBit("R2", outValid, 1'b0);
    checkVec("R2", lastExp);

    // constrained random
    for (int t = 0; t < 300; t++) begin
      int op;
      op = int'($urandom % 14);
      if (op == 13) op = 12 + int'($urandom % 4);
      runOp(op, int'($urandom % 16), 8'($urandom), 4'($urandom),
            4'($urandom), 1'($urandom), tagFor(op));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule